// File: doc/BRIEF.md
# External Interrupt Pin Port

This block watches seven external interrupt pins, numbered 1 to 7, and turns activity on them into interrupt requests. Each pin passes through a two-flop synchronizer. A per-pin two-bit sense field selects what counts as an event: a low level, a rising edge, a falling edge, or either edge. Edge events set a sticky flag that stays set until software writes a one to it. In low-level mode the flag follows the inverted pin instead.

A pin raises its request only while its flag is set and its enable bit is on. Each request carries a fixed priority level equal to its pin number, and this level cannot be reassigned. The block also reports the level of the highest-numbered active request.

Four registers sit on a simple register bus, all control-style with no handshake:
- sense selection,
- pin direction,
- request enable,
- flags.

Writes take effect on a clock edge. Reads are combinational. Pin index 0 does not exist, and its register bits are tied off.

Top module: `irq_edge_port`

## Requirements
- R1: The sense field of pin n sits at bits [2n+1:2n] of the sense register. It is encoded as 00 = low level, 01 = rising edge, 10 = falling edge, 11 = both edges.
- R2: A pin change driven before clock edge k shows in the flag register after clock edge k+2. This is two synchronizer flops plus the flag register.
- R3: In an edge mode, a detected edge sets the pin's flag. The flag stays set until a bus write with a one in that bit. A write with a zero in that bit leaves it unchanged.
- R4: In low-level mode the flag is 1 exactly while the synchronized pin is low. It is not sticky, and writes to the flag register do not clear it.
- R5: If an edge is detected in the same cycle as a one is written to clear that flag, the flag stays set.
- R6: req_o[n] is 1 exactly when flag n and enable bit n are both 1.
- R7: While a pin's direction bit is 1, the pin is not an input. No new flag is set for it, and its low-level flag reads 0.
- R8: Pin 0 does not exist. Sense bits [1:0] and bit 0 of the direction, enable and flag registers read 0 and ignore writes. req_o[0] is always 0.
- R9: level_o gives the fixed level of the highest-numbered active request, which is that pin's number. It is 0 when no request is active.
- R10: After reset all registers read 0, and req_o and level_o are 0.
- R11: The bus address selects the register: 0 = sense (16 bits), 1 = direction, 2 = enable, 3 = flags. The 8-bit registers are zero-extended on bus_rdata. A write occurs on a clock edge with bus_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | External interrupt pins; bit 0 unused |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| req_o | output | 8 | Per-pin interrupt requests; bit 0 always 0 |
| level_o | output | 3 | Level of the highest active request |

## Verification
The assertions take the synchronized pin as the only source of edges. They also assume the bus writes at most one register per cycle, with no relation to pin timing other than the edge/clear collision case.

The stimulus changes pins and bus signals only on falling clock edges. It holds every pin high through reset, so that no edge is seen on the way out of reset. Each pin change is held for at least three cycles, so every change passes through the synchronizer before the next one.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_SENSE = 2'd0;
  localparam logic [1:0] ADDR_DIR   = 2'd1;
  localparam logic [1:0] ADDR_ENA   = 2'd2;
  localparam logic [1:0] ADDR_FLAG  = 2'd3;
endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  // Pins idle high; reset to that value so leaving reset creates no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q      <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqp_detect.sv
module irqp_detect
  import irqp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [1:0] mode,
  input  logic       is_out,
  input  logic       clr,
  output logic       flag
);
  logic prev_q;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;

  always_comb begin
    hit = 1'b0;
    unique case (mode)
      SENSE_RISE: hit = rise;
      SENSE_FALL: hit = fall;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
    if (is_out) hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (mode == SENSE_LOW) flag <= ~is_out & ~pin_s;
    else                        flag <= hit | (flag & ~clr);
  end

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(clr) && $past(mode) != SENSE_LOW && mode != SENSE_LOW) |-> flag);

  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit) |=> flag);

  assert_output_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_out |=> !$rose(flag));

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW && !is_out) |=> (flag == !$past(pin_s)));
endmodule

// File: rtl/irqp_regs.sv
module irqp_regs
  import irqp_pkg::*;
#(
  parameter int N  = 8,
  localparam int DW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  flags,
  output logic [DW-1:0] sense_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  ena_q,
  output logic [N-1:0]  clr
);
  localparam logic [N-1:0]  PIN_MASK   = {{(N-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] SENSE_MASK = {{(DW-2){1'b1}}, 2'b00};

  logic [N-1:0] hi_unused;
  assign hi_unused = bus_wdata[DW-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      ena_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        ADDR_SENSE: sense_q <= bus_wdata & SENSE_MASK;
        ADDR_DIR:   dir_q   <= bus_wdata[N-1:0] & PIN_MASK;
        ADDR_ENA:   ena_q   <= bus_wdata[N-1:0] & PIN_MASK;
        default: ;
      endcase
    end
  end

  assign clr = (bus_we && bus_addr == ADDR_FLAG) ? (bus_wdata[N-1:0] & PIN_MASK) : '0;

  always_comb begin
    unique case (bus_addr)
      ADDR_SENSE: bus_rdata = sense_q;
      ADDR_DIR:   bus_rdata = {{(DW-N){1'b0}}, dir_q};
      ADDR_ENA:   bus_rdata = {{(DW-N){1'b0}}, ena_q};
      default:    bus_rdata = {{(DW-N){1'b0}}, flags & PIN_MASK};
    endcase
  end

  assert_pin0_tied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_q[1:0] == 2'b00) && !dir_q[0] && !ena_q[0]);

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_ENA) |=> (ena_q == ($past(bus_wdata[N-1:0]) & PIN_MASK)));
endmodule

// File: rtl/irqp_prio.sv
module irqp_prio #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [LW-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 1; i < N; i++)
      if (req[i]) level = LW'(i);
  end
endmodule

// File: rtl/irq_edge_port.sv
module irq_edge_port
  import irqp_pkg::*;
#(
  parameter int N  = 8,
  localparam int DW = 2 * N,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_i,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  req_o,
  output logic [LW-1:0] level_o
);
  logic [N-1:1]  pin_s;
  logic [N-1:0]  flags;
  logic [DW-1:0] sense_q;
  logic [N-1:0]  dir_q, ena_q, clr;
  logic          pin0_unused;

  assign pin0_unused = pin_i[0];

  irqp_sync #(.W(N-1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i[N-1:1]), .q(pin_s)
  );

  irqp_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
    .sense_q(sense_q), .dir_q(dir_q), .ena_q(ena_q), .clr(clr)
  );

  assign flags[0] = 1'b0;

  for (genvar i = 1; i < N; i++) begin : g_pin
    irqp_detect u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]),
      .mode(sense_q[2*i+1 : 2*i]), .is_out(dir_q[i]),
      .clr(clr[i]), .flag(flags[i])
    );
  end

  assign req_o = flags & ena_q;

  irqp_prio #(.N(N)) u_prio (.req(req_o), .level(level_o));

  assert_level_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o != '0) |-> ((req_o >> level_o) == N'(1)));

  assert_level_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o == '0) |-> (level_o == '0));

  assert_no_req0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o[0]);
endmodule

// File: tb/irq_edge_port_test.sv
module irq_edge_port_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = 8'hFF;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  req_o;
  logic [2:0]  level_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_edge_port uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_o(req_o), .level_o(level_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    @(negedge clk);
    tick(2);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R10 reg after reset", d, 0);
    end
    chk("R10 req after reset", req_o, 0);
    chk("R10 level after reset", level_o, 0);
    rst_n = 1'b1;
    tick(4);
    rd(2'd3, d);
    chk("R10 flags idle", d, 0);

    // R1 R2 R3 R4 R6 R9: sweep pins and sense modes
    wr(2'd2, 16'h00FE);
    for (int p = 1; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        int e1, e2;
        wr(2'd0, 16'(m << (2 * p)));
        wr(2'd3, 16'h00FF);
        e1 = (m != 1) ? 1 : 0;   // fall seen in low, falling, both
        e2 = (m != 0) ? 1 : 0;   // rise seen, or fall flag stays sticky
        pin_i[p] = 1'b0;
        tick(2);
        rd(2'd3, d);
        chk("R2 no flag before third edge", d, 0);
        tick(1);
        rd(2'd3, d);
        chk("R1 flag after low/fall", d, e1 << p);
        chk("R6 request follows flag", req_o, e1 << p);
        chk("R9 level equals pin", level_o, e1 ? p : 0);
        pin_i[p] = 1'b1;
        tick(3);
        rd(2'd3, d);
        chk("R3 R4 flag after rise", d, e2 << p);
        wr(2'd3, 16'h00FF);
        rd(2'd3, d);
        chk("R3 flag cleared by one", d, 0);
      end
    end

    // R3: writing zero leaves flag
    wr(2'd0, 16'(3 << 12));
    pin_i[6] = 1'b0; tick(3);
    wr(2'd3, 16'h0000);
    rd(2'd3, d);
    chk("R3 write zero keeps flag", d, 8'h40);
    pin_i[6] = 1'b1; tick(3);
    wr(2'd3, 16'h0040);

    // R4: level flag ignores clear
    wr(2'd0, 16'h0000);
    pin_i[2] = 1'b0; tick(3);
    wr(2'd3, 16'h0004);
    rd(2'd3, d);
    chk("R4 level flag ignores clear", d, 8'h04);
    pin_i[2] = 1'b1; tick(3);
    rd(2'd3, d);
    chk("R4 level flag drops with pin", d, 0);

    // R5: edge coincides with clear
    wr(2'd0, 16'(3 << 8));
    wr(2'd3, 16'h00FF);
    pin_i[4] = 1'b0; tick(3);
    pin_i[4] = 1'b1; tick(2);
    bus_addr = 2'd3; bus_wdata = 16'h0010; bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0;
    rd(2'd3, d);
    chk("R5 edge wins over clear", d, 8'h10);
    tick(2);
    rd(2'd3, d);
    chk("R5 flag stays after collision", d, 8'h10);
    wr(2'd3, 16'h0010);
    rd(2'd3, d);
    chk("R5 later clear works", d, 0);

    // R7: output pin sets no flag
    wr(2'd0, 16'(3 << 6));
    wr(2'd1, 16'h0008);
    pin_i[3] = 1'b0; tick(3);
    pin_i[3] = 1'b1; tick(3);
    rd(2'd3, d);
    chk("R7 output pin edge ignored", d, 0);
    wr(2'd0, 16'h0000);
    pin_i[3] = 1'b0; tick(3);
    rd(2'd3, d);
    chk("R7 output pin level ignored", d, 0);
    pin_i[3] = 1'b1;
    wr(2'd1, 16'h0000);
    tick(3);

    // R8 R11: pin 0 tied off, register map
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d);
    chk("R8 R11 sense pin0 bits", d, 16'hFFFC);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d);
    chk("R8 R11 direction pin0 bit", d, 16'h00FE);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d);
    chk("R8 R11 enable pin0 bit", d, 16'h00FE);
    wr(2'd3, 16'h00FF);
    pin_i[0] = 1'b0; tick(3);
    pin_i[0] = 1'b1; tick(3);
    rd(2'd3, d);
    chk("R8 pin0 toggles no flag", d, 0);
    chk("R8 no request on pin0", req_o[0], 0);

    // R9 R6: priority and enable gating
    pin_i[2] = 1'b0; pin_i[5] = 1'b0; tick(3);
    pin_i[2] = 1'b1; pin_i[5] = 1'b1; tick(3);
    chk("R9 highest level wins", level_o, 5);
    wr(2'd2, 16'h00DE);
    chk("R6 disabled pin drops request", req_o, 8'h04);
    chk("R9 level falls to next", level_o, 2);
    rd(2'd3, d);
    chk("R6 flag kept while disabled", d, 8'h24);
    wr(2'd3, 16'h00FF);
    chk("R9 idle level zero", level_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule